// File: doc/BRIEF.md
# Double-Edge Pin Capture with Half-Rate Gearbox

This block takes a bus of pin inputs and delivers it to core logic in one of four forms, selected by a parameter. In bypass form the pins reach the output through wires only. In single-rate form one register samples the pins on each rising edge of the fast clock. In double-edge form the pins are sampled on both edges of the fast clock, and the two samples come out together as one word pair that is aligned to the rising edge. In gearbox form two consecutive word pairs are packed into one beat that is four words wide and clocked by a slow clock at exactly half the fast rate, so the throughput is unchanged.

The output bus is a row of WIDTH-bit words. Word 0, in the lowest bits, always holds the oldest sample, and each word keeps its LSB on the right. One asynchronous reset pin and one synchronous reset pin are shared by every capture register. Parameters decide whether each of these pins clears or presets, or whether it is absent, so a clear and a preset of the same kind can never both be present. An optional clock enable freezes every register.

Top module: `gpio_ddr_capture`

## Requirements
- R1: The output width is WIDTH in bypass and single-rate modes, 2*WIDTH in double-edge mode and 4*WIDTH in gearbox mode.
- R2: In bypass mode data_out equals pad_in at all times, with no clock involved.
- R3: In single-rate mode, after rising edge T of clk_fr, data_out holds the pin value sampled at edge T.
- R4: In double-edge mode, after rising edge T, bits [WIDTH-1:0] hold the pins sampled at rising edge T-1 and bits [2*WIDTH-1:WIDTH] hold the pins sampled at the falling edge that follows edge T-1.
- R5: In gearbox mode, after a clk_hr rising edge that coincides with clk_fr rising edge T, words 0 to 3 (word k in bits [k*WIDTH +: WIDTH]) hold the rising sample of edge T-3, the falling sample after T-3, the rising sample of T-2 and the falling sample after T-2. The beat holds through the next clk_fr rising edge.
- R6: While arst is high, every register holds all zeros (clear kind) or all ones (preset kind), without waiting for a clock edge.
- R7: When srst is high at a register's active edge, that register loads all zeros (clear kind) or all ones (set kind).
- R8: With the clock enable option on, every register keeps its value while ce is low, and pin activity during that time does not reach the output.
- R9: The priority is arst first, then srst, then ce: a synchronous reset still acts while ce is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fr | input | 1 | Fast capture clock; both edges sample the pins |
| clk_hr | input | 1 | Slow clock at half the frequency of clk_fr, rising together with every second clk_fr rise; used only in gearbox mode |
| ce | input | 1 | Clock enable, active high; used only when USE_CE is set |
| arst | input | 1 | Asynchronous reset, active high; clears or presets according to ASYNC_KIND |
| srst | input | 1 | Synchronous reset, active high; clears or sets according to SYNC_KIND |
| pad_in | input | WIDTH | Pin bus to be captured |
| data_out | output | WIDTH, 2*WIDTH or 4*WIDTH | Captured data, oldest word in the lowest bits |

## Verification
The assertions take the two clocks to be phase aligned: clk_hr rises together with every second rising edge of clk_fr and falls on the rising edges in between, because the hold check on the half-rate beat counts fast edges between slow edges. They also take ce, srst and the release of arst to be synchronous and to stay clear of both clk_fr edges, since the falling-edge register samples them too. The bench generates both clocks in one process from a single toggle. It changes the pins, ce and srst only at quarter-period points, two nanoseconds after an edge, so every sample the history queue records is the value that the registers also saw.

// File: rtl/gpio_cap_pkg.sv
package gpio_cap_pkg;

  typedef enum logic [1:0] {
    CAP_BYPASS   = 2'd0,
    CAP_SDR      = 2'd1,
    CAP_DDR      = 2'd2,
    CAP_DDR_HALF = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    RST_NONE = 2'd0,
    RST_ZERO = 2'd1,
    RST_ONE  = 2'd2
  } rst_kind_e;

  // Number of WIDTH-bit words carried by one output beat.
  function automatic int words_per_beat(cap_mode_e m);
    case (m)
      CAP_DDR:      return 2;
      CAP_DDR_HALF: return 4;
      default:      return 1;
    endcase
  endfunction

  function automatic int bus_width(int w, cap_mode_e m);
    return w * words_per_beat(m);
  endfunction

  // Bit value loaded by a reset of the given kind.
  function automatic logic kind_bit(rst_kind_e k);
    return (k == RST_ONE);
  endfunction

endpackage

// File: rtl/gpio_cap_reg.sv
module gpio_cap_reg
  import gpio_cap_pkg::*;
#(
  parameter int        W          = 1,
  parameter bit        NEG_EDGE   = 1'b0,
  parameter bit        USE_CE     = 1'b0,
  parameter rst_kind_e ASYNC_KIND = RST_NONE,
  parameter rst_kind_e SYNC_KIND  = RST_NONE
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         ce,
  input  logic         srst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] ASYNC_VAL = {W{kind_bit(ASYNC_KIND)}};
  localparam logic [W-1:0] SYNC_VAL  = {W{kind_bit(SYNC_KIND)}};

  logic         sync_hit;
  logic         take;
  logic [W-1:0] nxt;
  logic         unused_pins;

  assign sync_hit    = (SYNC_KIND != RST_NONE) && srst;
  assign take        = !USE_CE || ce;
  assign unused_pins = ^{arst, ce, srst};

  // Synchronous reset outranks the clock enable.
  always_comb begin
    nxt = q;
    if (sync_hit)  nxt = SYNC_VAL;
    else if (take) nxt = d;
  end

  if (ASYNC_KIND == RST_NONE) begin : g_plain
    if (NEG_EDGE) begin : g_n
      always_ff @(negedge clk) q <= nxt;
    end else begin : g_p
      always_ff @(posedge clk) q <= nxt;
    end
  end else begin : g_async
    if (NEG_EDGE) begin : g_n
      always_ff @(negedge clk or posedge arst) begin
        if (arst) q <= ASYNC_VAL;
        else      q <= nxt;
      end
    end else begin : g_p
      always_ff @(posedge clk or posedge arst) begin
        if (arst) q <= ASYNC_VAL;
        else      q <= nxt;
      end
    end
  end

  if (NEG_EDGE) begin : g_chk_n
    if (USE_CE) begin : g_ce
      AST_HOLD_WITHOUT_CE: assert property (@(negedge clk) disable iff (arst) (!ce && !sync_hit) |=> $stable(q)); // R8
    end
    if (SYNC_KIND != RST_NONE) begin : g_sy
      AST_SYNC_LOAD: assert property (@(negedge clk) disable iff (arst) srst |=> (q == SYNC_VAL)); // R9
    end
    if (ASYNC_KIND != RST_NONE) begin : g_as
      AST_ASYNC_LEVEL: assert property (@(negedge clk) arst |-> (q == ASYNC_VAL)); // R6
    end
  end else begin : g_chk_p
    if (USE_CE) begin : g_ce
      AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (arst) (!ce && !sync_hit) |=> $stable(q)); // R8
    end
    if (SYNC_KIND != RST_NONE) begin : g_sy
      AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (arst) srst |=> (q == SYNC_VAL)); // R7
    end
    if (ASYNC_KIND != RST_NONE) begin : g_as
      AST_ASYNC_LEVEL: assert property (@(posedge clk) arst |-> (q == ASYNC_VAL)); // R6
    end
  end

endmodule

// File: rtl/gpio_ddr_front.sv
module gpio_ddr_front
  import gpio_cap_pkg::*;
#(
  parameter int        W          = 4,
  parameter bit        USE_CE     = 1'b1,
  parameter rst_kind_e ASYNC_KIND = RST_ZERO,
  parameter rst_kind_e SYNC_KIND  = RST_ZERO
) (
  input  logic           clk,
  input  logic           arst,
  input  logic           ce,
  input  logic           srst,
  input  logic [W-1:0]   pad,
  output logic [2*W-1:0] pair
);

  localparam int LANES = 2;

  logic [LANES*W-1:0] edge_q;

  // Lane 0 samples on the rising edge, lane 1 on the falling edge; both
  // are then retimed onto the rising edge so the pair changes together.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    gpio_cap_reg #(
      .W(W), .NEG_EDGE(k == 1), .USE_CE(USE_CE),
      .ASYNC_KIND(ASYNC_KIND), .SYNC_KIND(SYNC_KIND)
    ) u_sample (
      .clk(clk), .arst(arst), .ce(ce), .srst(srst),
      .d(pad), .q(edge_q[k*W +: W])
    );

    gpio_cap_reg #(
      .W(W), .NEG_EDGE(1'b0), .USE_CE(USE_CE),
      .ASYNC_KIND(ASYNC_KIND), .SYNC_KIND(SYNC_KIND)
    ) u_retime (
      .clk(clk), .arst(arst), .ce(ce), .srst(srst),
      .d(edge_q[k*W +: W]), .q(pair[k*W +: W])
    );
  end

  // Events brought out for the word-order check.
  logic       pass_ok;
  logic [1:0] seen_q;

  assign pass_ok = (!USE_CE || ce) && !((SYNC_KIND != RST_NONE) && srst);

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                seen_q <= 2'd0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  AST_RISE_TO_LOW: assert property (@(posedge clk) disable iff (arst) ((seen_q == 2'd3) && $past(pass_ok, 2) && $past(pass_ok)) |-> (pair[W-1:0] == $past(pad, 2))); // R4

endmodule

// File: rtl/gpio_rate_halver.sv
module gpio_rate_halver
  import gpio_cap_pkg::*;
#(
  parameter int        W          = 4,
  parameter bit        USE_CE     = 1'b1,
  parameter rst_kind_e ASYNC_KIND = RST_ZERO,
  parameter rst_kind_e SYNC_KIND  = RST_ZERO
) (
  input  logic           clk_fr,
  input  logic           clk_hr,
  input  logic           arst,
  input  logic           ce,
  input  logic           srst,
  input  logic [2*W-1:0] pair,
  output logic [4*W-1:0] beat
);

  logic [2*W-1:0] older_q;

  // Keeps the previous fast-rate pair so the slow edge sees two of them.
  gpio_cap_reg #(
    .W(2*W), .NEG_EDGE(1'b0), .USE_CE(USE_CE),
    .ASYNC_KIND(ASYNC_KIND), .SYNC_KIND(SYNC_KIND)
  ) u_older (
    .clk(clk_fr), .arst(arst), .ce(ce), .srst(srst),
    .d(pair), .q(older_q)
  );

  // Older pair in the low half, newer pair in the high half.
  gpio_cap_reg #(
    .W(4*W), .NEG_EDGE(1'b0), .USE_CE(USE_CE),
    .ASYNC_KIND(ASYNC_KIND), .SYNC_KIND(SYNC_KIND)
  ) u_beat (
    .clk(clk_hr), .arst(arst), .ce(ce), .srst(srst),
    .d({pair, older_q}), .q(beat)
  );

  // A fast rising edge seen with clk_hr high is mid-beat; the beat must
  // then survive until the next fast rising edge.
  AST_HALF_HOLD: assert property (@(posedge clk_fr) disable iff (arst) clk_hr |=> $stable(beat)); // R5

endmodule

// File: rtl/gpio_ddr_capture.sv
module gpio_ddr_capture
  import gpio_cap_pkg::*;
#(
  parameter int        WIDTH      = 4,
  parameter cap_mode_e MODE       = CAP_DDR_HALF,
  parameter bit        USE_CE     = 1'b1,
  parameter rst_kind_e ASYNC_KIND = RST_ZERO,
  parameter rst_kind_e SYNC_KIND  = RST_ZERO
) (
  input  logic                                 clk_fr,
  input  logic                                 clk_hr,
  input  logic                                 ce,
  input  logic                                 arst,
  input  logic                                 srst,
  input  logic [WIDTH-1:0]                     pad_in,
  output logic [bus_width(WIDTH, MODE)-1:0]    data_out
);

  localparam int OUT_W = bus_width(WIDTH, MODE);

  logic unused_inputs;
  assign unused_inputs = ^{clk_fr, clk_hr, ce, arst, srst};

  if (MODE == CAP_BYPASS) begin : g_bypass
    assign data_out = pad_in;
  end else if (MODE == CAP_SDR) begin : g_sdr
    gpio_cap_reg #(
      .W(OUT_W), .NEG_EDGE(1'b0), .USE_CE(USE_CE),
      .ASYNC_KIND(ASYNC_KIND), .SYNC_KIND(SYNC_KIND)
    ) u_sdr (
      .clk(clk_fr), .arst(arst), .ce(ce), .srst(srst),
      .d(pad_in), .q(data_out)
    );
  end else begin : g_ddr
    logic [2*WIDTH-1:0] pair;

    gpio_ddr_front #(
      .W(WIDTH), .USE_CE(USE_CE),
      .ASYNC_KIND(ASYNC_KIND), .SYNC_KIND(SYNC_KIND)
    ) u_front (
      .clk(clk_fr), .arst(arst), .ce(ce), .srst(srst),
      .pad(pad_in), .pair(pair)
    );

    if (MODE == CAP_DDR) begin : g_full
      assign data_out = pair;
    end else begin : g_half
      gpio_rate_halver #(
        .W(WIDTH), .USE_CE(USE_CE),
        .ASYNC_KIND(ASYNC_KIND), .SYNC_KIND(SYNC_KIND)
      ) u_halver (
        .clk_fr(clk_fr), .clk_hr(clk_hr), .arst(arst), .ce(ce), .srst(srst),
        .pair(pair), .beat(data_out)
      );
    end
  end

endmodule

// File: tb/sim_gpio_ddr_capture.sv
module sim_gpio_ddr_capture;
  import gpio_cap_pkg::*;

  localparam int W = 4;

  logic clk_fr = 1'b0;
  logic clk_hr = 1'b0;
  logic ce, arst, srst;
  logic [W-1:0]   pad;
  logic [4*W-1:0] q0;
  logic [2*W-1:0] q1;
  logic [W-1:0]   q2, q3;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // 125 MHz fast clock; slow clock toggles on every fast rise.
  initial forever begin
    #4 clk_fr = 1'b1; clk_hr = ~clk_hr;
    #4 clk_fr = 1'b0;
  end

  gpio_ddr_capture #(.WIDTH(W), .MODE(CAP_DDR_HALF), .USE_CE(1'b1),
                     .ASYNC_KIND(RST_ZERO), .SYNC_KIND(RST_ZERO)) u0 (
    .clk_fr(clk_fr), .clk_hr(clk_hr), .ce(ce), .arst(arst), .srst(srst),
    .pad_in(pad), .data_out(q0));

  gpio_ddr_capture #(.WIDTH(W), .MODE(CAP_DDR), .USE_CE(1'b1),
                     .ASYNC_KIND(RST_ONE), .SYNC_KIND(RST_ONE)) u1 (
    .clk_fr(clk_fr), .clk_hr(clk_hr), .ce(ce), .arst(arst), .srst(srst),
    .pad_in(pad), .data_out(q1));

  gpio_ddr_capture #(.WIDTH(W), .MODE(CAP_SDR), .USE_CE(1'b0),
                     .ASYNC_KIND(RST_NONE), .SYNC_KIND(RST_NONE)) u2 (
    .clk_fr(clk_fr), .clk_hr(clk_hr), .ce(ce), .arst(arst), .srst(srst),
    .pad_in(pad), .data_out(q2));

  gpio_ddr_capture #(.WIDTH(W), .MODE(CAP_BYPASS), .USE_CE(1'b0),
                     .ASYNC_KIND(RST_NONE), .SYNC_KIND(RST_NONE)) u3 (
    .clk_fr(clk_fr), .clk_hr(clk_hr), .ce(ce), .arst(arst), .srst(srst),
    .pad_in(pad), .data_out(q3));

  // Reference queue of pin samples, indexed by rising-edge number.
  logic [W-1:0] rise_h [64];
  logic [W-1:0] fall_h [64];
  int rc = 0;

  always @(posedge clk_fr) begin
    rise_h[rc % 64] = pad;
    rc = rc + 1;
  end
  always @(negedge clk_fr) fall_h[(rc - 1) % 64] = pad;

  function automatic logic [W-1:0] rs(int t); return rise_h[t % 64]; endfunction
  function automatic logic [W-1:0] fs(int t); return fall_h[t % 64]; endfunction

  function automatic logic [W-1:0] pat(int kind, int h);
    case (kind)
      0:       return W'(h);
      1:       return W'(1 << (h % W));
      2:       return W'($urandom);
      default: return (h % 2 == 1) ? W'(4'hA) : W'(4'h5);
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    ce = 1'b1; srst = 1'b0; arst = 1'b0; pad = '0;
    #1 arst = 1'b1;
    chk("R1 width gearbox", 16'($bits(u0.data_out)), 16'(4*W));
    chk("R1 width ddr",     16'($bits(u1.data_out)), 16'(2*W));
    chk("R1 width sdr",     16'($bits(u2.data_out)), 16'(W));
    chk("R1 width bypass",  16'($bits(u3.data_out)), 16'(W));
    repeat (3) @(posedge clk_fr);
    #1;
    chk("R6 clear after reset",  16'(q0), 16'h0000);
    chk("R6 preset after reset", 16'(q1), 16'(8'hFF));
    #1 arst = 1'b0;
  endtask

  // Drives a pin pattern on both half-periods and checks every mode.
  task automatic t_stream(int kind, int n);
    int t;
    int base;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_fr); #1;
      t = rc - 1;
      if (i >= 5) begin
        chk("R3 single-rate", 16'(q2), 16'(rs(t)));
        chk("R4 double-edge", 16'(q1), 16'({fs(t-1), rs(t-1)}));
        base = (clk_hr == 1'b1) ? t : t - 1;
        chk("R5 gearbox beat", 16'(q0), {fs(base-2), rs(base-2), fs(base-3), rs(base-3)});
        chk("R2 bypass", 16'(q3), 16'(pad));
      end
      #1 pad = pat(kind, 2*i);
      @(negedge clk_fr); #2 pad = pat(kind, 2*i + 1);
      #1 chk("R2 bypass mid", 16'(q3), 16'(pad));
    end
  endtask

  task automatic t_enable;
    logic [4*W-1:0] s0;
    logic [2*W-1:0] s1;
    @(posedge clk_fr); #1;
    s0 = q0; s1 = q1;
    #1 ce = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_fr); #1;
      chk("R8 gearbox held", 16'(q0), 16'(s0));
      chk("R8 double-edge held", 16'(q1), 16'(s1));
      #1 pad = W'($urandom);
      @(negedge clk_fr); #2 pad = W'($urandom);
    end
    ce = 1'b1;
  endtask

  task automatic t_sync(bit with_ce_low, string tag);
    @(posedge clk_fr); #2;
    srst = 1'b1;
    if (with_ce_low) ce = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk_fr); #1;
      chk(tag, 16'(q1), 16'(8'hFF));
      if (clk_hr == 1'b1) chk(tag, 16'(q0), 16'h0000);
      #1;
    end
    srst = 1'b0; ce = 1'b1;
  endtask

  task automatic t_async_mid;
    @(posedge clk_fr); #2 arst = 1'b1;
    #1;
    chk("R6 clear between edges",  16'(q0), 16'h0000);
    chk("R6 preset between edges", 16'(q1), 16'(8'hFF));
    @(posedge clk_fr); #1;
    chk("R6 clear held",  16'(q0), 16'h0000);
    chk("R6 preset held", 16'(q1), 16'(8'hFF));
    #1 arst = 1'b0;
  endtask

  initial begin
    t_reset();
    for (int k = 0; k < 4; k++) t_stream(k, 24);
    t_enable();
    t_stream(2, 16);
    t_sync(1'b0, "R7 sync reset");
    t_stream(0, 16);
    t_sync(1'b1, "R9 sync over enable");
    t_stream(3, 16);
    t_async_mid();
    t_stream(2, 16);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R1-wide run): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule